// File: doc/BRIEF.md
# Programmable UART Line Transmitter

This block turns bytes into asynchronous serial characters. Software-side logic writes a byte into a one-entry transmit holding register. On the next bit-rate enable pulse, the byte moves into a shift register and goes out on the serial line. The character starts with a low start bit. Then come 5 to 8 data bits, least-significant first, then an optional parity bit, then one or two high stop bits. Between characters the line rests high.

Run-time line-control inputs choose the word length, the parity mode (none, even, odd or stick) and the stop-bit count. The block captures these settings when a character starts. The holding-register-empty flag rises as soon as a byte has been moved into the shift register, so the next byte can be written while the current character is still on the line. A byte that is waiting is sent directly after the last stop bit, with no idle bit between the two characters. An external baud-rate generator supplies a one-clock enable per bit period. Every bit on the line lasts exactly one enable interval.

Top module: `uart_tx_line`

## Requirements
- R1: While no character is in progress (busy low), the serial output is held at 1.
- R2: Each character begins with a start bit driven as 0, lasting one bit interval.
- R3: A character starts only on a bit-rate enable pulse while the holding register holds unsent data. With no write, no start bit is ever produced.
- R4: The word-length code sets the data-bit count: 0→5, 1→6, 2→7, 3→8 bits. Only that many low-order bits of the byte are sent, and the frame length follows from the count.
- R5: Data bits are sent least-significant bit first.
- R6: With parity enabled and stick off, the parity bit follows the last data bit. When the even-select input is 1, the total number of 1s across the data and parity bits is even. When it is 0, that total is odd.
- R7: With parity enabled and stick on, the parity bit is the constant 0 when even-select is 1, and the constant 1 when even-select is 0.
- R8: Stop bits are driven as 1. There is one stop bit when the two-stop input is 0 and two when it is 1.
- R9: The empty flag falls on the clock after a write. It rises again when the byte is loaded at the start bit. A byte written during a character starts on the enable pulse that ends the last stop bit, with no idle gap.
- R10: Line-control inputs are captured at the start bit. Changing them during a character does not alter that character.
- R11: The serial output changes only on the clock edge where the bit-rate enable is high.
- R12: After reset, the serial output is 1, the empty flag is 1 and busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-clock enable per bit period |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| word_len | input | 2 | Data-bit count code (5 + code) |
| par_en | input | 1 | Parity bit enabled |
| par_even | input | 1 | Even parity select; for stick parity, 1 sends 0 |
| par_stick | input | 1 | Stick parity mode |
| two_stop | input | 1 | Two stop bits when 1 |
| txd | output | 1 | Serial line |
| thr_empty | output | 1 | Holding register empty |
| busy | output | 1 | Character in progress |

## Verification
A write shows on the empty flag one clock later. Every line result is due one clock after the enable pulse that causes it: the start bit and the rising empty flag, each data, parity and stop bit, and the return to idle. The bench raises the enable for a single clock at a falling edge and samples at the next falling edge, after the one rising edge in between. It then waits one more clock to confirm that the line holds steady while no enable is present. The expected frame is rebuilt bit by bit by counting ones in a loop, not from the reduction-XOR used in the design.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int DATA_W = 8;
  localparam int MIN_BITS = 5;
  localparam int CNT_W = $clog2(DATA_W);

  typedef struct packed {
    logic [1:0] wlen;
    logic       par_en;
    logic       par_even;
    logic       par_stick;
    logic       two_stop;
  } line_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP
  } tx_state_t;

  function automatic logic [3:0] data_count(input logic [1:0] wlen);
    return 4'(MIN_BITS) + {2'b00, wlen};
  endfunction

  function automatic logic [DATA_W-1:0] len_mask(input logic [1:0] wlen);
    return {DATA_W{1'b1}} >> (2'd3 - wlen);
  endfunction

  function automatic logic parity_calc(input logic [DATA_W-1:0] data,
                                       input line_cfg_t cfg);
    logic [DATA_W-1:0] kept;
    kept = data & len_mask(cfg.wlen);
    if (cfg.par_stick) return ~cfg.par_even;
    return cfg.par_even ? (^kept) : ~(^kept);
  endfunction
endpackage

// File: rtl/uart_tx_holding.sv
module uart_tx_holding
  import uart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_full
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_data <= '0;
      hold_full <= 1'b0;
    end else if (wr_en) begin
      hold_data <= wr_data;
      hold_full <= 1'b1;
    end else if (take) begin
      hold_full <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_tx_seq.sv
module uart_tx_seq
  import uart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  line_cfg_t         cfg_in,
  output logic              load,
  output logic              txd,
  output logic              busy
);
  tx_state_t         state;
  line_cfg_t         cfg_q;
  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  logic              stop_cnt;
  logic              par_q;
  logic              last_data;
  logic              last_stop;

  assign last_data = ({1'b0, bit_cnt} == data_count(cfg_q.wlen) - 4'd1);
  assign last_stop = (stop_cnt == cfg_q.two_stop);
  assign load = tick && hold_full &&
                ((state == ST_IDLE) || (state == ST_STOP && last_stop));
  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cfg_q    <= '0;
      shreg    <= '0;
      bit_cnt  <= '0;
      stop_cnt <= 1'b0;
      par_q    <= 1'b0;
      txd      <= 1'b1;
    end else if (load) begin
      state    <= ST_START;
      cfg_q    <= cfg_in;
      shreg    <= hold_data;
      par_q    <= parity_calc(hold_data, cfg_in);
      txd      <= 1'b0;
    end else if (tick) begin
      case (state)
        ST_START: begin
          txd     <= shreg[0];
          shreg   <= shreg >> 1;
          bit_cnt <= '0;
          state   <= ST_DATA;
        end
        ST_DATA: begin
          if (last_data) begin
            stop_cnt <= 1'b0;
            if (cfg_q.par_en) begin
              txd   <= par_q;
              state <= ST_PARITY;
            end else begin
              txd   <= 1'b1;
              state <= ST_STOP;
            end
          end else begin
            txd     <= shreg[0];
            shreg   <= shreg >> 1;
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        ST_PARITY: begin
          txd      <= 1'b1;
          stop_cnt <= 1'b0;
          state    <= ST_STOP;
        end
        ST_STOP: begin
          if (last_stop) begin
            txd   <= 1'b1;
            state <= ST_IDLE;
          end else begin
            stop_cnt <= 1'b1;
          end
        end
        default: begin
          txd   <= 1'b1;
          state <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_line.sv
module uart_tx_line
  import uart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        word_len,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              par_stick,
  input  logic              two_stop,
  output logic              txd,
  output logic              thr_empty,
  output logic              busy
);
  line_cfg_t         cfg_now;
  logic [DATA_W-1:0] hold_data;
  logic              hold_full;
  logic              load_evt;

  assign cfg_now = '{wlen: word_len, par_en: par_en, par_even: par_even,
                     par_stick: par_stick, two_stop: two_stop};
  assign thr_empty = ~hold_full;

  uart_tx_holding u_hold (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .take(load_evt), .hold_data(hold_data), .hold_full(hold_full)
  );

  uart_tx_seq u_seq (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .hold_full(hold_full),
    .hold_data(hold_data), .cfg_in(cfg_now), .load(load_evt),
    .txd(txd), .busy(busy)
  );
endmodule

// File: rtl/uart_tx_line_chk.sv
module uart_tx_line_chk (
  input logic clk,
  input logic rst_n,
  input logic baud_tick,
  input logic wr_en,
  input logic txd,
  input logic thr_empty,
  input logic busy,
  input logic load_evt
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd); // R1
  AST_START_IS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd); // R2
  AST_START_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!thr_empty)); // R3
  AST_LOAD_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> baud_tick); // R3
  AST_EMPTY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt && !wr_en |=> thr_empty); // R9
  AST_LINE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> $stable(txd)); // R11
endmodule

bind uart_tx_line uart_tx_line_chk u_chk (
  .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
  .txd(txd), .thr_empty(thr_empty), .busy(busy), .load_evt(load_evt)
);

// File: tb/uart_tx_line_tb.sv
module uart_tx_line_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] word_len = '0;
  logic       par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0, two_stop = 1'b0;
  logic       txd, thr_empty, busy;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  uart_tx_line u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
    .wr_data(wr_data), .word_len(word_len), .par_en(par_en),
    .par_even(par_even), .par_stick(par_stick), .two_stop(two_stop),
    .txd(txd), .thr_empty(thr_empty), .busy(busy)
  );

  // {data, word_len, par_en, par_even, par_stick, two_stop}
  localparam logic [13:0] VEC [8] = '{
    {8'hA5, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h3C, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'h3C, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1},
    {8'hFF, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'hE0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1},
    {8'h55, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0},
    {8'h55, 2'd2, 1'b1, 1'b1, 1'b1, 1'b1},
    {8'h81, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // one enable pulse; returns after the single rising edge that used it
  task automatic pulse();
    logic t;
    @(negedge clk) baud_tick = 1'b1;
    @(negedge clk) baud_tick = 1'b0;
    t = txd;
    @(negedge clk);
    check(txd, t, "R11 line steady without enable");
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  function automatic int frame_len(input logic [1:0] wl, input logic pe,
                                   input logic two);
    return 1 + 5 + int'(wl) + int'(pe) + 1 + int'(two);
  endfunction

  function automatic logic [12:0] frame_bits(input logic [7:0] d, input logic [1:0] wl,
      input logic pe, input logic ev, input logic st);
    logic [12:0] b;
    int k, ones;
    b = '1; k = 0; ones = 0;
    b[k] = 1'b0; k++;
    for (int i = 0; i < 5 + int'(wl); i++) begin
      b[k] = d[i]; k++;
      if (d[i]) ones++;
    end
    if (pe) begin
      if (st) b[k] = !ev;
      else if (ev) b[k] = (ones % 2 == 1);
      else b[k] = (ones % 2 == 0);
    end
    return b;
  endfunction

  task automatic run_frame(input logic [7:0] d, input logic [1:0] wl, input logic pe,
      input logic ev, input logic st, input logic two,
      input bit skip_start, input bit pending_next, input bit scramble);
    logic [12:0] exp;
    int n, len;
    string tg;
    exp = frame_bits(d, wl, pe, ev, st);
    len = frame_len(wl, pe, two);
    n = 5 + int'(wl);
    for (int i = (skip_start ? 1 : 0); i < len; i++) begin
      pulse();
      if (i == 0) tg = "R2 start bit";
      else if (i <= n) tg = "R5 data bit";
      else if (pe && i == n + 1) tg = st ? "R7 stick parity" : "R6 parity";
      else tg = "R8 stop bit";
      if (scramble) tg = {tg, " R10"};
      check(txd, exp[i], tg);
      check(busy, 1'b1, "R2 busy during frame");
      if (i == 0 && !pending_next) check(thr_empty, 1'b1, "R9 empty at load");
      if (i == 0 && scramble) begin
        word_len = ~wl; par_en = ~pe; par_even = ~ev; par_stick = ~st; two_stop = ~two;
      end
    end
    pulse();
    if (pending_next) begin
      check(txd, 1'b0, "R9 next start without gap");
      check(thr_empty, 1'b1, "R9 empty after second load");
    end else begin
      check(txd, 1'b1, "R4 frame length / R1 idle");
      check(busy, 1'b0, "R4 frame ends");
    end
  endtask

  task automatic set_cfg(input logic [1:0] wl, input logic pe, input logic ev,
                         input logic st, input logic two);
    @(negedge clk) begin
      word_len = wl; par_en = pe; par_even = ev; par_stick = st; two_stop = two;
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(txd, 1'b1, "R12 reset txd");
    check(thr_empty, 1'b1, "R12 reset empty");
    check(busy, 1'b0, "R12 reset busy");
    @(negedge clk) rst_n = 1'b1;

    // R3: enable pulses with nothing written
    for (int i = 0; i < 4; i++) begin
      pulse();
      check(txd, 1'b1, "R3 no start without write");
      check(busy, 1'b0, "R3 stays idle");
    end

    // table walk
    foreach (VEC[v]) begin
      set_cfg(VEC[v][5:4], VEC[v][3], VEC[v][2], VEC[v][1], VEC[v][0]);
      write_byte(VEC[v][13:6]);
      check(thr_empty, 1'b0, "R9 full after write");
      check(txd, 1'b1, "R3 no start before enable");
      run_frame(VEC[v][13:6], VEC[v][5:4], VEC[v][3], VEC[v][2], VEC[v][1],
                VEC[v][0], 1'b0, 1'b0, 1'b0);
    end

    // R10: settings changed after the start bit
    set_cfg(2'd1, 1'b1, 1'b0, 1'b0, 1'b1);
    write_byte(8'h2D);
    run_frame(8'h2D, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);

    // R9: back-to-back characters
    set_cfg(2'd3, 1'b1, 1'b1, 1'b0, 1'b0);
    write_byte(8'hC3);
    pulse();
    check(txd, 1'b0, "R2 first start");
    write_byte(8'h5A);
    check(thr_empty, 1'b0, "R9 second byte waiting");
    run_frame(8'hC3, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    run_frame(8'h5A, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule